// File: doc/BRIEF.md
# Dual-Mode Cartridge Bank Controller

This block sits between a CPU bus and the memories of a cartridge. Writes into the lower half of the address space (0x0000–0x7FFF) do not reach any memory. Instead, address bits 14:13 decode each one into one of four control registers: an external RAM enable, a 5-bit ROM bank, a 2-bit secondary register and a mode bit.

From that state, the block forms two outputs, both combinational:

- the physical ROM address for the switchable 16 KiB window at 0x4000–0x7FFF;
- the physical RAM address for the 8 KiB window at 0xA000–0xBFFF.

The mode bit decides what the secondary register feeds. In mode 0 it extends the ROM bank number upward, giving physical address bits 20:19. In mode 1 it picks one of four RAM banks instead.

Both physical addresses are trimmed by size masks given as parameters. A RAM write strobe is produced only for writes into the RAM window while RAM is enabled on a build that has RAM.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset, RAM is disabled, the ROM bank is 1, the secondary register is 0 and the mode is 0. An access at 0x4000 therefore maps to physical ROM address 0x04000.
- R2: A write with address bit 15 low and bits 14:13 = 00 enables RAM when (data & 0x0A) == 0x0A, and disables it for any other data.
- R3: A write with bit 15 low and bits 14:13 = 01 stores data bits 4:0 as the ROM bank. When those five bits are zero, the bank stored is 1.
- R4: In mode 0 the ROM address is {secondary, bank, cpu_addr[13:0]}, with the secondary register at bits 20:19, ANDed with ROM_MASK.
- R5: In mode 1 the ROM address is {bank, cpu_addr[13:0]} ANDed with ROM_MASK, and the RAM address is {secondary, cpu_addr[12:0]} ANDed with RAM_MASK. In mode 0 the RAM bank is 0.
- R6: A write with bit 15 low and bits 14:13 = 10 loads data bits 1:0 into the secondary register. Bits 14:13 = 11 loads data bit 0 into the mode bit.
- R7: ram_we is high only while cpu_wr is high, cpu_addr lies in 0xA000–0xBFFF, RAM is enabled and RAM_BYTES is nonzero.
- R8: Writes with address bit 15 high leave every register unchanged. A register write changes the address outputs from the clock edge that samples it.
- R9: The ROM_MASK and RAM_MASK parameters clear the physical address bits beyond the configured sizes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| rom_addr | output | ROM_AW | Physical ROM address for the switchable window |
| ram_addr | output | RAM_AW | Physical external RAM address |
| ram_we | output | 1 | External RAM write enable |

## Verification
Two instances run side by side on the same stimulus: one with full-size masks and RAM, one with a 1 MiB ROM mask and no RAM. A difference between them therefore isolates the masking and the RAM-present gate.

RAM-enable data values are chosen so that only bits 3 and 1 matter:

- 0x0A and 0xFA must enable;
- 0x08, 0x02 and 0x00 must disable.

This separates a correct two-bit test from a full-byte compare.

ROM bank writes include 0x00 and 0xE0, which must both become bank 1, and 0x3F, whose upper bits must be dropped. Switching the mode with a nonzero secondary value shows that the value moves between the ROM high bits and the RAM bank.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

    localparam int BANK_W = 5;
    localparam int SEC_W  = 2;

    typedef enum logic [1:0] {
        SEL_RAM_EN   = 2'b00,
        SEL_ROM_BANK = 2'b01,
        SEL_SEC      = 2'b10,
        SEL_MODE     = 2'b11
    } reg_sel_e;

    typedef struct packed {
        logic              ram_en;
        logic [BANK_W-1:0] rom_bank;
        logic [SEC_W-1:0]  sec;
        logic              mode;
    } bank_state_t;

    localparam bank_state_t STATE_RESET = '{
        ram_en:   1'b0,
        rom_bank: BANK_W'(1),
        sec:      '0,
        mode:     1'b0
    };

endpackage

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
    import cart_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_wr,
    output bank_state_t state_q
);

    bank_state_t state_d;
    logic        reg_hit;

    assign reg_hit = cpu_wr && !cpu_addr[15];

    always_comb begin
        state_d = state_q;
        if (reg_hit) begin
            case (reg_sel_e'(cpu_addr[14:13]))
                SEL_RAM_EN:   state_d.ram_en = ((cpu_wdata & 8'h0A) == 8'h0A);
                SEL_ROM_BANK: state_d.rom_bank = (cpu_wdata[BANK_W-1:0] == '0)
                                                 ? BANK_W'(1) : cpu_wdata[BANK_W-1:0];
                SEL_SEC:      state_d.sec = cpu_wdata[SEC_W-1:0];
                SEL_MODE:     state_d.mode = cpu_wdata[0];
                default:      state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= STATE_RESET;
        else        state_q <= state_d;
    end

    // R2
    ram_en_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b000) |=>
            (state_q.ram_en == ($past(cpu_wdata[3:0] & 4'hA) == 4'hA)));

    // R3
    bank_zero_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b001 && cpu_wdata[4:0] == 5'd0) |=>
            (state_q.rom_bank == 5'd1));

    // R6
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b011) |=> (state_q.mode == $past(cpu_wdata[0])));

    // R8
    upper_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cpu_wr && !cpu_addr[15])) |=> $stable(state_q));

endmodule

// File: rtl/cart_bank_map.sv
module cart_bank_map
    import cart_bank_pkg::*;
#(
    parameter int              ROM_AW    = 21,
    parameter int              RAM_AW    = 15,
    parameter logic [ROM_AW-1:0] ROM_MASK = '1,
    parameter logic [RAM_AW-1:0] RAM_MASK = '1,
    parameter int              RAM_BYTES = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_state_t       state_q,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_wr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we
);

    localparam int ROM_RAW_W = SEC_W + BANK_W + 14;
    localparam int RAM_RAW_W = SEC_W + 13;

    logic [SEC_W-1:0]     rom_hi;
    logic [SEC_W-1:0]     ram_bank;
    logic [ROM_RAW_W-1:0] rom_raw;
    logic [RAM_RAW_W-1:0] ram_raw;
    logic                 in_ram_win;

    always_comb begin
        rom_hi   = state_q.mode ? '0 : state_q.sec;
        ram_bank = state_q.mode ? state_q.sec : '0;
        rom_raw  = {rom_hi, state_q.rom_bank, cpu_addr[13:0]};
        ram_raw  = {ram_bank, cpu_addr[12:0]};
        rom_addr = ROM_AW'(rom_raw) & ROM_MASK;
        ram_addr = RAM_AW'(ram_raw) & RAM_MASK;
        in_ram_win = (cpu_addr[15:13] == 3'b101);
    end

    generate
        if (RAM_BYTES != 0) begin : g_ram
            assign ram_we = cpu_wr && in_ram_win && state_q.ram_en;
        end else begin : g_no_ram
            assign ram_we = 1'b0;
        end
    endgenerate

    // R7
    ram_we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (state_q.ram_en && cpu_wr && cpu_addr[15:13] == 3'b101 && RAM_BYTES != 0));

    generate
        if (RAM_AW > 13) begin : g_bank_chk
            // R5
            mode0_ram_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !state_q.mode |-> (ram_addr[RAM_AW-1:13] == '0));
        end
    endgenerate

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cart_bank_pkg::*;
#(
    parameter int                ROM_AW    = 21,
    parameter int                RAM_AW    = 15,
    parameter logic [ROM_AW-1:0] ROM_MASK  = '1,
    parameter logic [RAM_AW-1:0] RAM_MASK  = '1,
    parameter int                RAM_BYTES = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we
);

    bank_state_t state_q;

    cart_bank_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_wr    (cpu_wr),
        .state_q   (state_q)
    );

    cart_bank_map #(
        .ROM_AW    (ROM_AW),
        .RAM_AW    (RAM_AW),
        .ROM_MASK  (ROM_MASK),
        .RAM_MASK  (RAM_MASK),
        .RAM_BYTES (RAM_BYTES)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_q   (state_q),
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .rom_addr  (rom_addr),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we)
    );

    // R3
    bank_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.rom_bank != '0);

endmodule

// File: tb/tb_cart_bank_ctrl.sv
module tb_cart_bank_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [20:0] SMALL_ROM_MASK = 21'h0FFFFF;
    localparam logic [14:0] SMALL_RAM_MASK = 15'h1FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [20:0] rom_addr, rom_addr_s;
    logic [14:0] ram_addr, ram_addr_s;
    logic        ram_we, ram_we_s;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // bench-side view of the programmed state
    bit       m_en;
    bit [4:0] m_bank;
    bit [1:0] m_sec;
    bit       m_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_bank_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .rom_addr(rom_addr), .ram_addr(ram_addr), .ram_we(ram_we)
    );

    cart_bank_ctrl #(
        .ROM_MASK(SMALL_ROM_MASK), .RAM_MASK(SMALL_RAM_MASK), .RAM_BYTES(0)
    ) dut_small (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .rom_addr(rom_addr_s), .ram_addr(ram_addr_s), .ram_we(ram_we_s)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [20:0] exp_rom(logic [15:0] a, logic [20:0] mask);
        logic [1:0] hi;
        hi = m_mode ? 2'b00 : m_sec;
        return {hi, m_bank, a[13:0]} & mask;
    endfunction

    function automatic logic [14:0] exp_ram(logic [15:0] a, logic [14:0] mask);
        logic [1:0] rb;
        rb = m_mode ? m_sec : 2'b00;
        return {rb, a[12:0]} & mask;
    endfunction

    task automatic reg_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        if (a[15] == 1'b0) begin
            case (a[14:13])
                2'b00: m_en = ((d & 8'h0A) == 8'h0A);
                2'b01: m_bank = (d[4:0] == 5'd0) ? 5'd1 : d[4:0];
                2'b10: m_sec = d[1:0];
                default: m_mode = d[0];
            endcase
        end
    endtask

    task automatic probe_rom(string tag, logic [15:0] a);
        cpu_addr = a; cpu_wr = 1'b0;
        #1;
        check(tag, 32'(rom_addr), 32'(exp_rom(a, 21'h1FFFFF)));
        check(tag, 32'(rom_addr_s), 32'(exp_rom(a, SMALL_ROM_MASK)));
    endtask

    task automatic probe_ram(string tag, logic [15:0] a);
        cpu_addr = a; cpu_wr = 1'b0;
        #1;
        check(tag, 32'(ram_addr), 32'(exp_ram(a, 15'h7FFF)));
        check(tag, 32'(ram_addr_s), 32'(exp_ram(a, SMALL_RAM_MASK)));
    endtask

    // strobe a write in the data area and look at the write enables while it is up
    task automatic probe_we(string tag, logic [15:0] a, bit exp_we);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = 8'h5A; cpu_wr = 1'b1;
        #1;
        check(tag, 32'(ram_we), 32'(exp_we));
        check(tag, 32'(ram_we_s), 32'(0));
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic t_reset();
        m_en = 0; m_bank = 5'd1; m_sec = 2'd0; m_mode = 0;
        @(negedge clk);
        probe_rom("R1 reset rom", 16'h4000);
        check("R1 reset rom value", 32'(rom_addr), 32'h04000);
        probe_ram("R1 reset ram", 16'hA000);
        probe_we("R1 reset ram disabled", 16'hA123, 1'b0);
    endtask

    task automatic t_ram_enable();
        reg_write(16'h0000, 8'h0A); probe_we("R2 0x0A enables", 16'hA010, 1'b1);
        reg_write(16'h1FFF, 8'h08); probe_we("R2 0x08 disables", 16'hA010, 1'b0);
        reg_write(16'h0100, 8'hFA); probe_we("R2 0xFA enables", 16'hBFFF, 1'b1);
        reg_write(16'h0000, 8'h02); probe_we("R2 0x02 disables", 16'hB000, 1'b0);
        reg_write(16'h0000, 8'h0B); probe_we("R7 enabled in window", 16'hA000, 1'b1);
        probe_we("R7 below window", 16'h9FFF, 1'b0);
        probe_we("R7 above window", 16'hC000, 1'b0);
    endtask

    task automatic t_rom_bank();
        reg_write(16'h2000, 8'h00); probe_rom("R3 zero becomes one", 16'h4000);
        reg_write(16'h3000, 8'h3F); probe_rom("R3 upper data bits dropped", 16'h7FFF);
        check("R3 bank 31 value", 32'(rom_addr), 32'h7FFFF);
        reg_write(16'h2000, 8'hE0); probe_rom("R3 zero low bits become one", 16'h5555);
        reg_write(16'h2000, 8'h07); probe_rom("R3 bank 7", 16'h6001);
    endtask

    task automatic t_mode0();
        reg_write(16'h4000, 8'hFE); probe_rom("R4 mode0 secondary high bits", 16'h4ABC);
        check("R4 mode0 value", 32'(rom_addr), 32'h11CABC);
        check("R9 small mask drops bit 20", 32'(rom_addr_s), 32'h01CABC);
        probe_ram("R5 mode0 ram bank zero", 16'hB234);
        reg_write(16'h5000, 8'h01); probe_rom("R6 secondary 1", 16'h4000);
    endtask

    task automatic t_mode1();
        reg_write(16'h4000, 8'h03);
        reg_write(16'h6000, 8'hFF);
        probe_rom("R5 mode1 rom ignores secondary", 16'h4ABC);
        check("R5 mode1 rom value", 32'(rom_addr), 32'h1CABC);
        probe_ram("R5 mode1 ram bank 3", 16'hB234);
        check("R5 mode1 ram value", 32'(ram_addr), 32'h7234);
        check("R9 small ram mask", 32'(ram_addr_s), 32'h1234);
        reg_write(16'h7FFF, 8'hFE);
        probe_rom("R6 mode back to 0", 16'h4ABC);
    endtask

    task automatic t_ignored();
        // upper half writes touch no register
        reg_write(16'h8000, 8'h01);
        reg_write(16'hA000, 8'h00);
        reg_write(16'hC000, 8'h6F);
        reg_write(16'hE000, 8'h01);
        probe_rom("R8 upper writes ignored", 16'h4321);
        probe_we("R8 enable unchanged", 16'hA001, 1'b1);
        // register update visible exactly at the sampling edge
        @(negedge clk);
        cpu_addr = 16'h2000; cpu_wdata = 8'h12; cpu_wr = 1'b1;
        #1;
        check("R8 no change before edge", 32'(rom_addr), 32'(exp_rom(16'h2000, 21'h1FFFFF) & 21'h1FFFFF));
        @(posedge clk); #1;
        cpu_wr = 1'b0;
        m_bank = 5'h12;
        probe_rom("R8 change after edge", 16'h4000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_ram_enable();
        t_rom_bank();
        t_mode0();
        t_mode1();
        t_ignored();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule